// File: doc/BRIEF.md
# Multi-Mode Timer Base with Shared Interrupt Vector

This block is the time base of a timer peripheral. A counter, normally 16 bits wide, advances on ticks taken from one of several clock-enable strobes. The strobe passes through a power-of-two prescaler first. The counter can be halted, or it can run in three counting patterns: it can climb to a period value and restart at zero, it can run freely over the whole range, or it can climb to the period and fall back to zero. The period value comes from the first compare channel, which sits outside this block.

A flag is raised whenever the counter comes back to zero. A vector output encodes the most urgent pending shared interrupt: one of the compare channels numbered from one upward, or the counter wrap. Asserting the read strobe for the vector acknowledges the source it shows. For a channel source, the block pulses a clear line back to that channel. For a wrap source, it drops its own wrap flag. A single control write port sets the mode, the divider, the strobe source and the wrap interrupt enable. The same write can also restart the count.

Top module: `tmr_base`

## Requirements
- R1: After reset the counter is 0, the direction is up (`cnt_down`=0), the wrap flag is 0, the vector is 0 and `ctl_q` reads 0.
- R2: With the mode field at 00 (halt), the counter keeps its value on every cycle.
- R3: With mode 01, each tick adds one to the counter while it is below `period_val`. When the counter is at or above the period, the next tick loads 0.
- R4: With mode 10, each tick adds one, and the counter wraps from 0xFFFF to 0.
- R5: With mode 11, ticks move the counter up to `period_val` and then down to 0, repeatedly. `cnt_down` is 1 on every step strictly after the turn at the period and before the return to 0. A period of 0 keeps the counter at 0.
- R6: The divider field `ctl_wdata[3:2]` makes one tick from every 1, 2, 4 or 8 selected strobes (codes 00, 01, 10, 11).
- R7: The source field `ctl_wdata[1:0]` selects which bit of `clk_en_src` is counted. Strobes on the other bits do not move the counter.
- R8: A control write with bit 6 set forces the counter to 0, the direction to up and the prescaler count to 0 on that write's clock edge. Bit 6 is not stored, so `ctl_q[6]` reads 0.
- R9: The wrap flag sets on the clock edge where a tick takes a nonzero counter to 0. `ovf_irq` is high while both the flag and the enable bit `ctl_wdata[7]` (as stored) are 1.
- R10: The vector reads 2·k for the lowest-numbered channel k (from 1) whose flag and enable are both 1. If no channel qualifies, it reads 10 when the wrap flag and its enable are both 1. Otherwise it reads 0.
- R11: Asserting `vec_rd` pulses `ch_flag_clr` for the channel that the vector shows in that cycle. If the vector shows the wrap source, the wrap flag clears on that edge, unless a new wrap happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data: [1:0] source, [3:2] divider, [5:4] mode, [6] restart, [7] wrap enable |
| clk_en_src | input | NSRC (4) | Candidate clock-enable strobes |
| period_val | input | CNT_W (16) | Period value from compare channel 0 |
| ch_flag | input | NCH (2) | Pending flags of shared channels 1..NCH |
| ch_ie | input | NCH (2) | Interrupt enables of shared channels 1..NCH |
| vec_rd | input | 1 | Vector read/acknowledge strobe |
| ctl_q | output | 8 | Stored control value, restart bit reading 0 |
| cnt_val | output | CNT_W (16) | Counter value |
| cnt_down | output | 1 | Counting direction, 1 = down |
| ovf_flag | output | 1 | Wrap flag |
| ovf_irq | output | 1 | Wrap interrupt request |
| vec_val | output | 4 | Highest-priority pending shared source code |
| ch_flag_clr | output | NCH (2) | One-cycle clear pulses to channel flags |

## Verification
The up and up/down modes are swept over every divider code and over periods of 0, 1, 3 and 6. The expected count and direction are derived from the number of elapsed strobes, so this sweep separates the wrap point, the turn point and the divider ratio. A free-running pass through 65536 ticks confirms the full-range wrap and the first setting of the wrap flag. Alternating strobe patterns are applied, with the selected bit pulsed and every other bit pulsed on the opposite cycles, and these patterns expose a wrong source pick. All flag and enable combinations are applied to the vector with the wrap enable both on and off, which shows the priority order. Restarts are issued mid-count, including during a down phase, to confirm that the direction resets and that the prescaler count resets.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_HALT = 2'b00,
      MODE_UP   = 2'b01,
      MODE_FREE = 2'b10,
      MODE_UPDN = 2'b11
   } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int NSRC  = 4,
   parameter int DIV_W = 2,
   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  strobes,
   input  logic [SRC_W-1:0] src_sel,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             run,
   input  logic             restart,
   output logic             tick
);
   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (SRC_W'(i) == src_sel) picked = strobes[i];
      end
   end

   generate
      if (DIV_W == 0) begin : g_nodiv
         assign tick = picked & run & ~restart;
      end else begin : g_div
         localparam int PRE_W = (1 << DIV_W) - 1;
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] mask;
         logic             hit;

         always_comb begin
            mask = PRE_W'((1 << div_sel) - 1);
            hit  = picked && run && ((pre_q & mask) == mask);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart) begin
               pre_q <= '0;
            end else if (picked && run) begin
               pre_q <= hit ? '0 : pre_q + 1'b1;
            end
         end

         assign tick = hit & ~restart;
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             down,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_nxt;
   logic             down_nxt;

   always_comb begin
      cnt_nxt  = cnt;
      down_nxt = down;
      if (restart) begin
         cnt_nxt  = '0;
         down_nxt = 1'b0;
      end else if (tick) begin
         unique case (mode)
            MODE_UP: begin
               cnt_nxt  = (cnt >= period) ? '0 : cnt + ONE;
               down_nxt = 1'b0;
            end
            MODE_FREE: begin
               cnt_nxt  = cnt + ONE;
               down_nxt = 1'b0;
            end
            MODE_UPDN: begin
               if (!down) begin
                  if (cnt >= period) begin
                     if (cnt == '0) begin
                        cnt_nxt = '0;
                     end else begin
                        cnt_nxt  = cnt - ONE;
                        down_nxt = (cnt != ONE);
                     end
                  end else begin
                     cnt_nxt = cnt + ONE;
                  end
               end else begin
                  if (cnt <= ONE) begin
                     cnt_nxt  = '0;
                     down_nxt = 1'b0;
                  end else begin
                     cnt_nxt = cnt - ONE;
                  end
               end
            end
            default: begin
               cnt_nxt  = cnt;
               down_nxt = down;
            end
         endcase
      end
   end

   assign wrap = !restart && tick && (cnt != '0) && (cnt_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b0;
      end else begin
         cnt  <= cnt_nxt;
         down <= down_nxt;
      end
   end
endmodule

// File: rtl/tmr_vec_enc.sv
module tmr_vec_enc #(
   parameter int NCH      = 2,
   parameter int VEC_W    = 4,
   parameter int OVF_CODE = 10
) (
   input  logic [NCH-1:0]   ch_flag,
   input  logic [NCH-1:0]   ch_ie,
   input  logic             ovf_pend,
   input  logic             rd,
   output logic [VEC_W-1:0] vec,
   output logic [NCH-1:0]   ch_clr,
   output logic             ovf_clr
);
   logic [NCH-1:0] pend;
   logic [NCH-1:0] win;
   logic           any_ch;

   assign pend = ch_flag & ch_ie;

   always_comb begin
      win = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend[i]) win = NCH'(1) << i;
      end
   end

   assign any_ch = |pend;

   always_comb begin
      vec = '0;
      for (int i = 0; i < NCH; i++) begin
         if (win[i]) vec = VEC_W'(2 * (i + 1));
      end
      if (!any_ch && ovf_pend) vec = VEC_W'(OVF_CODE);
   end

   assign ch_clr  = rd ? win : '0;
   assign ovf_clr = rd && !any_ch && ovf_pend;
endmodule

// File: rtl/tmr_base.sv
module tmr_base
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int NSRC     = 4,
   parameter int DIV_W    = 2,
   parameter int NCH      = 2,
   parameter int VEC_W    = 4,
   parameter int OVF_CODE = 10,
   localparam int SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1,
   localparam int DIV_LSB  = SRC_W,
   localparam int MODE_LSB = SRC_W + DIV_W,
   localparam int CLR_BIT  = MODE_LSB + 2,
   localparam int IE_BIT   = CLR_BIT + 1,
   localparam int CTL_W    = IE_BIT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic [NSRC-1:0]  clk_en_src,
   input  logic [CNT_W-1:0] period_val,
   input  logic [NCH-1:0]   ch_flag,
   input  logic [NCH-1:0]   ch_ie,
   input  logic             vec_rd,
   output logic [CTL_W-1:0] ctl_q,
   output logic [CNT_W-1:0] cnt_val,
   output logic             cnt_down,
   output logic             ovf_flag,
   output logic             ovf_irq,
   output logic [VEC_W-1:0] vec_val,
   output logic [NCH-1:0]   ch_flag_clr
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tmr_base: CNT_W must be at least 2");
      end
      if (NSRC != (1 << SRC_W)) begin : g_bad_src
         $error("tmr_base: NSRC must be a power of two");
      end
      if (DIV_W > 3) begin : g_bad_div
         $error("tmr_base: DIV_W above 3 is not supported");
      end
      if ((OVF_CODE <= 2 * NCH) || (OVF_CODE % 2 != 0)) begin : g_bad_code
         $error("tmr_base: OVF_CODE must be even and above every channel code");
      end
      if (OVF_CODE >= (1 << VEC_W)) begin : g_bad_vw
         $error("tmr_base: VEC_W too narrow for OVF_CODE");
      end
   endgenerate

   logic [SRC_W-1:0] src_q;
   logic [DIV_W-1:0] div_q;
   tmr_mode_e        mode_q;
   logic             ie_q;
   logic             restart;
   logic             tick;
   logic             wrap;
   logic             ovf_clr;

   assign restart = ctl_we & ctl_wdata[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         div_q  <= '0;
         mode_q <= MODE_HALT;
         ie_q   <= 1'b0;
      end else if (ctl_we) begin
         src_q  <= ctl_wdata[SRC_W-1:0];
         div_q  <= ctl_wdata[DIV_LSB +: DIV_W];
         mode_q <= tmr_mode_e'(ctl_wdata[MODE_LSB +: 2]);
         ie_q   <= ctl_wdata[IE_BIT];
      end
   end

   assign ctl_q = {ie_q, 1'b0, mode_q, div_q, src_q};

   tmr_tick_gen #(
      .NSRC  (NSRC),
      .DIV_W (DIV_W)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobes (clk_en_src),
      .src_sel (src_q),
      .div_sel (div_q),
      .run     (mode_q != MODE_HALT),
      .restart (restart),
      .tick    (tick)
   );

   tmr_count_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .tick    (tick),
      .restart (restart),
      .period  (period_val),
      .cnt     (cnt_val),
      .down    (cnt_down),
      .wrap    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
      end else if (wrap) begin
         ovf_flag <= 1'b1;
      end else if (ovf_clr) begin
         ovf_flag <= 1'b0;
      end
   end

   assign ovf_irq = ovf_flag & ie_q;

   tmr_vec_enc #(
      .NCH      (NCH),
      .VEC_W    (VEC_W),
      .OVF_CODE (OVF_CODE)
   ) u_vec (
      .ch_flag  (ch_flag),
      .ch_ie    (ch_ie),
      .ovf_pend (ovf_irq),
      .rd       (vec_rd),
      .vec      (vec_val),
      .ch_clr   (ch_flag_clr),
      .ovf_clr  (ovf_clr)
   );
endmodule

// File: rtl/tmr_base_chk.sv
module tmr_base_chk #(
   parameter int CNT_W    = 16,
   parameter int NCH      = 2,
   parameter int VEC_W    = 4,
   parameter int CTL_W    = 8,
   parameter int MODE_LSB = 4,
   parameter int CLR_BIT  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic [CTL_W-1:0] ctl_q,
   input logic [CNT_W-1:0] period_val,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cnt_down,
   input logic             ovf_flag,
   input logic [NCH-1:0]   ch_flag_clr
);
   logic [1:0] mode;
   assign mode = ctl_q[MODE_LSB +: 2];

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !ctl_we) |=> $stable(cnt_val)); // R2

   AST_UP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !ctl_we && cnt_val <= period_val) |=> (cnt_val <= $past(period_val))); // R3

   AST_DOWN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !ctl_we && cnt_down) |=> (cnt_val <= $past(cnt_val))); // R5

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CLR_BIT]) |=> (cnt_val == '0 && !cnt_down)); // R8

   AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_val != '0 && !ctl_we) |=> (cnt_val != '0 || ovf_flag)); // R9

   AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_flag_clr)); // R11
endmodule

bind tmr_base tmr_base_chk #(
   .CNT_W    (CNT_W),
   .NCH      (NCH),
   .VEC_W    (VEC_W),
   .CTL_W    (CTL_W),
   .MODE_LSB (MODE_LSB),
   .CLR_BIT  (CLR_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we      (ctl_we),
   .ctl_wdata   (ctl_wdata),
   .ctl_q       (ctl_q),
   .period_val  (period_val),
   .cnt_val     (cnt_val),
   .cnt_down    (cnt_down),
   .ovf_flag    (ovf_flag),
   .ch_flag_clr (ch_flag_clr)
);

// File: tb/tmr_base_tb_top.sv
module tmr_base_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [3:0]  clk_en_src = '0;
   logic [15:0] period_val = '0;
   logic [1:0]  ch_flag = '0;
   logic [1:0]  ch_ie = '0;
   logic        vec_rd = 1'b0;
   logic [7:0]  ctl_q;
   logic [15:0] cnt_val;
   logic        cnt_down;
   logic        ovf_flag;
   logic        ovf_irq;
   logic [3:0]  vec_val;
   logic [1:0]  ch_flag_clr;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   tmr_base dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_we      (ctl_we),
      .ctl_wdata   (ctl_wdata),
      .clk_en_src  (clk_en_src),
      .period_val  (period_val),
      .ch_flag     (ch_flag),
      .ch_ie       (ch_ie),
      .vec_rd      (vec_rd),
      .ctl_q       (ctl_q),
      .cnt_val     (cnt_val),
      .cnt_down    (cnt_down),
      .ovf_flag    (ovf_flag),
      .ovf_irq     (ovf_irq),
      .vec_val     (vec_val),
      .ch_flag_clr (ch_flag_clr)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] cw(input int src, input int dv, input int md,
                                     input bit clr, input bit ie);
      return {ie, clr, 2'(md), 2'(dv), 2'(src)};
   endfunction

   task automatic wr(input logic [7:0] v);
      ctl_we    = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_we    = 1'b0;
   endtask

   task automatic drain_wrap();
      ch_ie = '0;
      #1;
      if (vec_val == 4'd10) begin
         vec_rd = 1'b1;
         @(negedge clk);
         vec_rd = 1'b0;
      end
   endtask

   function automatic longint updn_val(input longint t, input longint p);
      longint m;
      if (p == 0) return 0;
      m = t % (2 * p);
      return (m <= p) ? m : 2 * p - m;
   endfunction

   task automatic sweep(input int md, input int dv, input int p, input int kmax);
      longint t, e, first;
      period_val = 16'(p);
      drain_wrap();
      wr(cw(0, dv, md, 1'b1, 1'b1));
      first = (p == 0) ? 64'h7fffffff : ((md == 1) ? p + 1 : 2 * p);
      for (int k = 0; k <= kmax; k++) begin
         t = k >> dv;
         if (md == 1) begin
            e = t % (p + 1);
            chk("R3 R6 up count", cnt_val, e);
         end else begin
            e = updn_val(t, p);
            chk("R5 R6 updown count", cnt_val, e);
            chk("R5 direction", cnt_down, (p > 0) && ((t % (2 * p)) > p));
         end
         chk("R9 wrap flag", ovf_flag, t >= first);
         chk("R9 wrap irq", ovf_irq, t >= first);
         if (k != kmax) @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      longint e, hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", cnt_val, 0);
      chk("R1 direction", cnt_down, 0);
      chk("R1 wrap flag", ovf_flag, 0);
      chk("R1 vector", vec_val, 0);
      chk("R1 control", ctl_q, 0);

      clk_en_src = 4'b0001;

      // R3 R5 R6 sweeps
      for (int dv = 0; dv < 4; dv++) begin
         foreach (period_list[i]) begin
            sweep(1, dv, period_list[i], 40);
            sweep(3, dv, period_list[i], 60);
         end
      end

      // R4 free running across full range
      period_val = 16'd3;
      drain_wrap();
      wr(cw(0, 0, 2, 1'b1, 1'b1));
      for (int k = 0; k <= 65538; k++) begin
         chk("R4 free count", cnt_val, k % 65536);
         chk("R9 free wrap flag", ovf_flag, k >= 65536);
         @(negedge clk);
      end

      // R2 halt keeps value
      wr(cw(0, 0, 0, 1'b0, 1'b1));
      hold = cnt_val;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk("R2 halt hold", cnt_val, hold);
      end

      // R8 restart during down phase
      period_val = 16'd6;
      wr(cw(0, 0, 3, 1'b1, 1'b1));
      repeat (8) @(negedge clk);
      chk("R5 mid down count", cnt_val, 4);
      chk("R5 mid down dir", cnt_down, 1);
      wr(cw(0, 0, 3, 1'b1, 1'b1));
      chk("R8 restart count", cnt_val, 0);
      chk("R8 restart dir", cnt_down, 0);
      chk("R8 restart bit reads 0", ctl_q[6], 0);

      // R8 prescaler restarted
      period_val = 16'd100;
      wr(cw(0, 3, 1, 1'b1, 1'b1));
      repeat (5) @(negedge clk);
      wr(cw(0, 3, 1, 1'b1, 1'b1));
      repeat (7) @(negedge clk);
      chk("R8 prescaler reset before 8th", cnt_val, 0);
      @(negedge clk);
      chk("R8 prescaler reset at 8th", cnt_val, 1);

      // R7 source selection
      for (int s = 0; s < 4; s++) begin
         wr(cw(s, 0, 2, 1'b1, 1'b1));
         e = 0;
         for (int i = 0; i < 16; i++) begin
            clk_en_src = (i % 2 == 1) ? 4'(1 << s) : (~4'(1 << s));
            @(negedge clk);
            if (i % 2 == 1) e++;
            chk("R7 selected source", cnt_val, e);
         end
      end
      clk_en_src = 4'b0001;

      // R10 vector priority sweep
      period_val = 16'd1;
      wr(cw(0, 0, 1, 1'b1, 1'b1));
      repeat (3) @(negedge clk);
      for (int ie = 0; ie < 2; ie++) begin
         wr(cw(0, 0, 0, 1'b0, 1'(ie)));
         chk("R9 irq follows enable", ovf_irq, ie);
         for (int f = 0; f < 4; f++) begin
            for (int en = 0; en < 4; en++) begin
               ch_flag = 2'(f);
               ch_ie   = 2'(en);
               #1;
               e = ((f & en & 1) != 0) ? 2 : ((f & en & 2) != 0) ? 4 : (ie != 0) ? 10 : 0;
               chk("R10 vector code", vec_val, e);
               @(negedge clk);
            end
         end
      end

      // R11 acknowledge
      ch_flag = 2'b11;
      ch_ie   = 2'b11;
      vec_rd  = 1'b1;
      #1;
      chk("R11 channel 1 clear pulse", ch_flag_clr, 1);
      ch_ie = 2'b10;
      #1;
      chk("R11 channel 2 clear pulse", ch_flag_clr, 2);
      @(negedge clk);
      chk("R11 wrap kept on channel ack", ovf_flag, 1);
      ch_ie = 2'b00;
      #1;
      chk("R11 no channel pulse on wrap ack", ch_flag_clr, 0);
      @(negedge clk);
      vec_rd = 1'b0;
      chk("R11 wrap flag cleared", ovf_flag, 0);
      chk("R11 vector after ack", vec_val, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int period_list [4] = '{0, 1, 3, 6};
endmodule